// File: doc/BRIEF.md
# Timer Output Compare Override Unit

This block is the output compare stage of a 16-bit free-running timer with eight channels. Each channel owns a compare register; when the counter steps off a value equal to that register, the channel raises a flag and, for channels 0 to 6, applies a two-bit pin action: none, toggle, clear or set. Channel 7 is a master channel. Its own compare match, or a counter wrap while its wrap enable is on, forms a master event. On that event, preset levels from a data register are forced onto the pins picked by a mask register, and they take priority over any compare on the lower channels in the same cycle.

A pin is touched only when its channel is configured for output compare and connected to the pin. All configuration sits behind a small word-wide register bus with a combinational read path. A build parameter removes the master channel. The mask and data registers then read as zero and ignore writes.

Top module: `tmr_oc_override`

## Requirements
- R1: The counter adds one on each cycle with `tick_en` high, wraps from 0xFFFF to 0x0000 and sets `ovf_flag` on the wrap. A bus write to the count register (address 15) loads it and takes priority over the tick. With no tick and no write, the counter holds.
- R2: A channel hit is a cycle with `tick_en` high and the counter equal to that channel's compare register (addresses 0 to 7). A hit sets bit n of `cmp_flag`. Writing 1 to a bit of the flag register (address 14: bits 7:0 for the channels, bit 8 for the overflow) clears it. A hit in the same cycle as the clear wins.
- R3: On a hit, a lower channel n (0 to 6) applies its action code from address 12, bits [2n+1:2n]: 00 none, 01 toggle, 10 clear, 11 set.
- R4: A master event is a hit on channel 7, or a wrap while bit 0 of the control register (address 13) is 1. A wrap with that bit at 0 is not a master event.
- R5: On a master event, each pin whose mask bit is 1 takes the matching data bit, even if its own channel hits in the same cycle.
- R6: On a master event, pins whose mask bit is 0 keep their own channel behaviour.
- R7: A pin changes only when its bit in the output-compare select register (address 10) is 1 and its bit in the disconnect register (address 11) is 0. Otherwise it is left alone by both its own action and the master event.
- R8: The mask (address 8) and data (address 9) registers reset to zero and can be written and read back at any time.
- R9: A master event in the same cycle as a bus write to mask or data uses the values held before that write.
- R10: Built without the master channel, mask and data read zero, writes to them have no effect and no override reaches the pins.
- R11: Pins are registered. They reset to zero and change on the clock edge that ends the hit cycle. With no hit on a live channel and no master event, they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter advance enable for this cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_out | output | 8 | Registered timer pin levels |
| cmp_flag | output | 8 | Per-channel compare flags |
| ovf_flag | output | 1 | Counter wrap flag |

## Verification
The hardest case to reach from the ports is a master event that coincides with compares on the lower channels and with a register write, on pins that differ in mask, select and disconnect settings. Reaching it by counting up to matching values would take thousands of cycles. The stimulus instead loads the counter through the bus, places the chosen compare registers on that value and issues a single tick. This makes every hit land in one known cycle. The wrap case uses the same shortcut, loading the counter with 0xFFFF just before the tick.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_act_e;

  // next level of one pin given its own action code
  function automatic logic apply_act(input logic cur, input logic [1:0] code);
    case (oc_act_e'(code))
      ACT_TOGGLE: return ~cur;
      ACT_CLEAR:  return 1'b0;
      ACT_SET:    return 1'b1;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr_oc_cmp.sv
module tmr_oc_cmp #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic [CW-1:0] cmp_val [NCH],
  input  logic [NCH:0]  flg_clr,
  output logic [CW-1:0] cnt,
  output logic [NCH-1:0] hit,
  output logic          ovf_evt,
  output logic [NCH-1:0] flags,
  output logic          ovf_flag
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  for (genvar i = 0; i < NCH; i++) begin : g_match
    assign hit[i] = tick_en && (cnt == cmp_val[i]);
  end

  assign ovf_evt = tick_en && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      flags    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (cnt_wr)       cnt <= cnt_wdata;
      else if (tick_en) cnt <= cnt + CW'(1);
      flags    <= (flags & ~flg_clr[NCH-1:0]) | hit;
      ovf_flag <= (ovf_flag & ~flg_clr[NCH]) | ovf_evt;
    end
  end

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !cnt_wr |=> cnt == $past(cnt) + CW'(1)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !cnt_wr |=> $stable(cnt)); // R1
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag); // R1
  AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> (flags & $past(hit)) == $past(hit)); // R2

endmodule

// File: rtl/tmr_oc_regs.sv
module tmr_oc_regs #(
  parameter int NCH        = 8,
  parameter int CW         = 16,
  parameter int HAS_MASTER = 1,
  parameter int AW         = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [CW-1:0]        bus_wdata,
  input  logic [CW-1:0]        cnt,
  input  logic [NCH-1:0]       flags,
  input  logic                 ovf_flag,
  output logic [CW-1:0]        cmp_val [NCH],
  output logic [NCH-1:0]       mask_q,
  output logic [NCH-1:0]       data_q,
  output logic [NCH-1:0]       ios_q,
  output logic [NCH-1:0]       dis_q,
  output logic [2*NCH-3:0]     act_q,
  output logic                 tov_q,
  output logic                 cnt_wr,
  output logic [NCH:0]         flg_clr,
  output logic [CW-1:0]        rdata
);

  localparam int IW = $clog2(NCH);
  localparam int ACW = 2 * (NCH - 1);
  localparam logic [AW-1:0] A_MASK = AW'(NCH);
  localparam logic [AW-1:0] A_DATA = AW'(NCH + 1);
  localparam logic [AW-1:0] A_IOS  = AW'(NCH + 2);
  localparam logic [AW-1:0] A_DIS  = AW'(NCH + 3);
  localparam logic [AW-1:0] A_ACT  = AW'(NCH + 4);
  localparam logic [AW-1:0] A_CTL  = AW'(NCH + 5);
  localparam logic [AW-1:0] A_FLG  = AW'(NCH + 6);
  localparam logic [AW-1:0] A_CNT  = AW'(NCH + 7);

  logic cmp_sel;
  assign cmp_sel = bus_addr < AW'(NCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_val <= '{default: '0};
      ios_q   <= '0;
      dis_q   <= '0;
      act_q   <= '0;
      tov_q   <= 1'b0;
    end else if (bus_wr) begin
      if (cmp_sel) cmp_val[bus_addr[IW-1:0]] <= bus_wdata;
      case (bus_addr)
        A_IOS:   ios_q <= bus_wdata[NCH-1:0];
        A_DIS:   dis_q <= bus_wdata[NCH-1:0];
        A_ACT:   act_q <= bus_wdata[ACW-1:0];
        A_CTL:   tov_q <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  if (HAS_MASTER != 0) begin : g_master
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= '0;
        data_q <= '0;
      end else if (bus_wr) begin
        if (bus_addr == A_MASK) mask_q <= bus_wdata[NCH-1:0];
        if (bus_addr == A_DATA) data_q <= bus_wdata[NCH-1:0];
      end
    end
  end else begin : g_reserved
    assign mask_q = '0;
    assign data_q = '0;
  end

  assign cnt_wr  = bus_wr && (bus_addr == A_CNT);
  assign flg_clr = (bus_wr && bus_addr == A_FLG) ? bus_wdata[NCH:0] : '0;

  always_comb begin
    rdata = '0;
    if (cmp_sel) rdata = cmp_val[bus_addr[IW-1:0]];
    else begin
      case (bus_addr)
        A_MASK:  rdata = CW'(mask_q);
        A_DATA:  rdata = CW'(data_q);
        A_IOS:   rdata = CW'(ios_q);
        A_DIS:   rdata = CW'(dis_q);
        A_ACT:   rdata = CW'(act_q);
        A_CTL:   rdata = CW'(tov_q);
        A_FLG:   rdata = CW'({ovf_flag, flags});
        A_CNT:   rdata = cnt;
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_oc_pins.sv
module tmr_oc_pins
  import tmr_oc_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int HAS_MASTER = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   hit,
  input  logic             ovf_evt,
  input  logic             tov,
  input  logic [NCH-1:0]   mask,
  input  logic [NCH-1:0]   data,
  input  logic [NCH-1:0]   ios,
  input  logic [NCH-1:0]   dis,
  input  logic [2*NCH-3:0] act,
  output logic             master_evt,
  output logic [NCH-1:0]   live,
  output logic [NCH-1:0]   ovr_sel,
  output logic [NCH-1:0]   pin
);

  logic [NCH-1:0] pin_nxt;

  assign master_evt = (HAS_MASTER != 0) && (hit[NCH-1] || (ovf_evt && tov));
  assign live       = ios & ~dis;
  assign ovr_sel    = master_evt ? (mask & live) : '0;

  for (genvar i = 0; i < NCH - 1; i++) begin : g_lower
    assign pin_nxt[i] = ovr_sel[i]            ? data[i] :
                        (hit[i] && live[i])   ? apply_act(pin[i], act[2*i +: 2]) :
                                                pin[i];
  end
  assign pin_nxt[NCH-1] = ovr_sel[NCH-1] ? data[NCH-1] : pin[NCH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= '0;
    else        pin <= pin_nxt;
  end

  AST_OVR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    master_evt |=> ((pin ^ $past(data)) & $past(ovr_sel)) == '0); // R5
  AST_DEAD_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit) || master_evt) |=> ((pin ^ $past(pin)) & ~$past(live)) == '0); // R7
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(hit & live)) && !master_evt) |=> $stable(pin)); // R11

endmodule

// File: rtl/tmr_oc_override.sv
module tmr_oc_override #(
  parameter int NCH        = 8,
  parameter int CW         = 16,
  parameter int HAS_MASTER = 1,
  localparam int AW        = $clog2(NCH + 8)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] cmp_flag,
  output logic           ovf_flag
);

  logic [CW-1:0]    cmp_val [NCH];
  logic [NCH-1:0]   mask_q, data_q, ios_q, dis_q;
  logic [2*NCH-3:0] act_q;
  logic             tov_q;
  logic             cnt_wr;
  logic [NCH:0]     flg_clr;
  logic [CW-1:0]    cnt;
  logic [NCH-1:0]   hit;
  logic             ovf_evt;
  logic             master_evt;
  logic [NCH-1:0]   live;
  logic [NCH-1:0]   ovr_sel;

  tmr_oc_regs #(.NCH(NCH), .CW(CW), .HAS_MASTER(HAS_MASTER), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt(cnt), .flags(cmp_flag), .ovf_flag(ovf_flag),
    .cmp_val(cmp_val), .mask_q(mask_q), .data_q(data_q), .ios_q(ios_q),
    .dis_q(dis_q), .act_q(act_q), .tov_q(tov_q), .cnt_wr(cnt_wr),
    .flg_clr(flg_clr), .rdata(bus_rdata)
  );

  tmr_oc_cmp #(.NCH(NCH), .CW(CW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr),
    .cnt_wdata(bus_wdata), .cmp_val(cmp_val), .flg_clr(flg_clr), .cnt(cnt),
    .hit(hit), .ovf_evt(ovf_evt), .flags(cmp_flag), .ovf_flag(ovf_flag)
  );

  tmr_oc_pins #(.NCH(NCH), .HAS_MASTER(HAS_MASTER)) u_pins (
    .clk(clk), .rst_n(rst_n), .hit(hit), .ovf_evt(ovf_evt), .tov(tov_q),
    .mask(mask_q), .data(data_q), .ios(ios_q), .dis(dis_q), .act(act_q),
    .master_evt(master_evt), .live(live), .ovr_sel(ovr_sel), .pin(pin_out)
  );

  AST_MASTER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    master_evt |-> (hit[NCH-1] || (ovf_evt && tov_q))); // R4
  AST_OVR_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_sel & ~mask_q) == '0); // R6

endmodule

// File: tb/tmr_oc_override_bench.sv
module tmr_oc_override_bench;

  localparam int A_MASK = 8, A_DATA = 9, A_IOS = 10, A_DIS = 11;
  localparam int A_ACT = 12, A_CTL = 13, A_FLG = 14, A_CNT = 15;
  localparam int WDOG = 20000;

  typedef struct packed {
    logic [7:0]  mask;
    logic [7:0]  data;
    logic [7:0]  ios;
    logic [7:0]  dis;
    logic [13:0] act;
    logic [6:0]  lo;
    logic        m7;
    logic [7:0]  exp_pin;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'h00, 8'hFF, 8'h00, 14'h1555, 7'h7F, 1'b0, 8'h7F},
    '{8'h00, 8'h00, 8'hFF, 8'h00, 14'h2AAA, 7'h0F, 1'b0, 8'h70},
    '{8'h00, 8'h00, 8'h01, 8'h00, 14'h3FFF, 7'h03, 1'b0, 8'h71},
    '{8'hFF, 8'h0F, 8'hFF, 8'h00, 14'h1555, 7'h7F, 1'b1, 8'h0F},
    '{8'hF0, 8'hF0, 8'hFF, 8'h30, 14'h3FFF, 7'h0F, 1'b1, 8'hCF},
    '{8'h0F, 8'h00, 8'hF0, 8'h00, 14'h1555, 7'h70, 1'b1, 8'hBF},
    '{8'hFF, 8'h00, 8'hFF, 8'h00, 14'h0000, 7'h7F, 1'b0, 8'hBF},
    '{8'h81, 8'h00, 8'hFF, 8'h00, 14'h2AAA, 7'h7E, 1'b1, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, nm_rdata;
  logic [7:0]  pin_out, nm_pin;
  logic [7:0]  cmp_flag, nm_flag;
  logic        ovf_flag, nm_ovf;
  int          n_run = 0;
  int          n_fail = 0;
  int          cycles = 0;

  always #10 clk = ~clk;

  tmr_oc_override u_tmr_oc_override (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
  );

  tmr_oc_override #(.HAS_MASTER(0)) u_tmr_oc_override_nm (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(nm_rdata),
    .pin_out(nm_pin), .cmp_flag(nm_flag), .ovf_flag(nm_ovf)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwr(input int addr, input logic [15:0] val);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(addr); bus_wdata = val;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input int addr, output logic [15:0] val);
    @(negedge clk);
    bus_addr = 4'(addr);
    #1 val = bus_rdata;
  endtask

  task automatic tick1();
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WDOG);
      finish_run();
    end
  end

  initial begin
    logic [15:0] rd;
    logic [7:0]  nm_before;
    repeat (3) @(negedge clk);
    // R11, R8: reset state
    check("R11 reset pins", 16'(pin_out), 16'h0);
    check("R2 reset flags", {7'h0, ovf_flag, cmp_flag}, 16'h0);
    brd(A_MASK, rd); check("R8 reset mask", rd, 16'h0);
    brd(A_DATA, rd); check("R8 reset data", rd, 16'h0);
    rst_n = 1'b1;
    brd(A_CNT, rd);  check("R1 reset count", rd, 16'h0);

    // R8: readback
    bwr(A_MASK, 16'h005A); brd(A_MASK, rd); check("R8 mask rw", rd, 16'h005A);
    bwr(A_DATA, 16'h00C3); brd(A_DATA, rd); check("R8 data rw", rd, 16'h00C3);

    // vector table: R3 R5 R6 R7 R2
    for (int v = 0; v < NV; v++) begin
      bwr(A_FLG, 16'h01FF);
      bwr(A_MASK, 16'(VEC[v].mask));
      bwr(A_DATA, 16'(VEC[v].data));
      bwr(A_IOS,  16'(VEC[v].ios));
      bwr(A_DIS,  16'(VEC[v].dis));
      bwr(A_ACT,  16'(VEC[v].act));
      bwr(A_CTL,  16'h0000);
      for (int c = 0; c < 7; c++) bwr(c, VEC[v].lo[c] ? 16'h0100 : 16'h0200);
      bwr(7, VEC[v].m7 ? 16'h0100 : 16'h0300);
      bwr(A_CNT, 16'h0100);
      tick1();
      check($sformatf("R3/R5/R6/R7 vector %0d pins", v), 16'(pin_out), 16'(VEC[v].exp_pin));
      check($sformatf("R2 vector %0d flags", v), 16'(cmp_flag), 16'({VEC[v].m7, VEC[v].lo}));
    end

    // R1: counting
    for (int c = 0; c < 8; c++) bwr(c, 16'h0200);
    bwr(A_CNT, 16'h0010);
    @(negedge clk); tick_en = 1'b1;
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    brd(A_CNT, rd); check("R1 five ticks", rd, 16'h0015);

    // R1, R4: wrap as master event
    bwr(A_FLG, 16'h01FF);
    bwr(A_MASK, 16'h00FF); bwr(A_DATA, 16'h00A5);
    bwr(A_IOS, 16'h00FF);  bwr(A_DIS, 16'h0000); bwr(A_ACT, 16'h0000);
    bwr(A_CTL, 16'h0001);
    bwr(A_CNT, 16'hFFFF);
    tick1();
    check("R4 wrap override pins", 16'(pin_out), 16'h00A5);
    check("R1 wrap flag", 16'(ovf_flag), 16'h1);
    brd(A_CNT, rd); check("R1 wrap to zero", rd, 16'h0000);

    // R2: write one clears only the selected flag
    bwr(A_FLG, 16'h0000);
    check("R2 zero write keeps flag", 16'(ovf_flag), 16'h1);
    bwr(A_FLG, 16'h0100);
    check("R2 clear overflow", 16'(ovf_flag), 16'h0);

    // R4: wrap without enable does not override
    bwr(A_CTL, 16'h0000); bwr(A_DATA, 16'h005A);
    bwr(A_CNT, 16'hFFFF);
    tick1();
    check("R4 wrap without enable pins", 16'(pin_out), 16'h00A5);
    check("R1 wrap flag again", 16'(ovf_flag), 16'h1);

    // R9: same-cycle write uses old data
    bwr(A_DATA, 16'h003C);
    bwr(7, 16'h0100);
    bwr(A_CNT, 16'h0100);
    @(negedge clk);
    tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 4'(A_DATA); bus_wdata = 16'h00FF;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    check("R9 old data used", 16'(pin_out), 16'h003C);
    brd(A_DATA, rd); check("R9 new data stored", rd, 16'h00FF);

    // R10: build without master channel
    brd(A_MASK, rd); check("R10 reserved mask read", 16'(nm_rdata), 16'h0);
    brd(A_DATA, rd); check("R10 reserved data read", 16'(nm_rdata), 16'h0);
    bwr(A_DATA, 16'h0000);
    bwr(A_CNT, 16'h0100);
    nm_before = nm_pin;
    bwr(A_DATA, 16'h00FF);
    tick1();
    check("R10 no override without master", 16'(nm_pin), 16'(nm_before));
    check("R5 master build override", 16'(pin_out), 16'h00FF);

    finish_run();
  end

endmodule